// File: doc/BRIEF.md
# Physical Memory Attribute Gate

This block stands between a hart's load/store pipeline and the system bus. Each incoming request carries an address, an access kind (load, store or atomic), a size and a tag. A fixed table of address regions sorts every physical address into main memory, I/O or vacant space, and gives each region its own access rules. A request that breaks the rules of its region is rejected with a precise access fault in the cycle it is presented. A request that passes is forwarded to the bus in that same cycle. A rejected request never reaches the bus, so it can never come back as a bus error.

Responses from the bus are also routed through the block. An error on a forwarded read comes back as a precise fault that carries the tag of the load that caused it. An error on a forwarded write can no longer be made precise. It sets a sticky bus-error interrupt instead, which also records the address of the first failing write. Software acknowledges the interrupt with a one-cycle clear pulse.

Top module: `pma_gate`

## Requirements
- R1: Region lookup is fixed at build time. When several regions contain an address, the region with the lowest index decides. An address that no region contains is vacant. Defaults: region 0 is I/O at 0x1000_0000, 4 KiB, word-only, no atomics. Region 1 is I/O at 0x1000_0000, 64 KiB, read-only. Region 2 is main memory at 0x8000_0000, 256 MiB, with no restriction. Region 3 is explicitly vacant at 0x2000_0000, 4 KiB.
- R2: Every request to vacant space is rejected with a fault, whatever its kind or size, and it is not forwarded.
- R3: When `req_valid` and `req_ready` are high, exactly one of two things happens in that same cycle. Either `fwd_valid` rises with the address, kind, size and tag copied unchanged, or `flt_valid` rises with `flt_tag` equal to `req_tag`. A rejected request never raises `fwd_valid`.
- R4: A request address with any bit set at or above bit `PA_W` (32 by default) is treated as vacant.
- R5: In a word-only region, only size code 2 (four bytes) is allowed. Size codes 0, 1 and 3 stand for 1, 2 and 8 bytes, and all three fault.
- R6: A no-atomics region rejects kind code 2 (atomic) but still allows loads (kind 0) and stores (kind 1).
- R7: A read-only region allows loads and rejects stores and atomics.
- R8: An access-fault cause is 1 for a load. It is 2 for a store, an atomic, or the reserved kind code 3, and kind code 3 is always rejected.
- R9: A bus response with `rsp_err` high and `rsp_wr` low does three things in the same cycle. It raises `flt_valid` with cause 3 and `flt_tag` equal to `rsp_tag`. It drives `req_ready` low. It keeps `fwd_valid` low.
- R10: A bus response with `rsp_err` and `rsp_wr` both high sets `berr_irq` from the next cycle on. `berr_addr` holds the address of the first failing write. Later write errors leave `berr_irq` set and leave `berr_addr` unchanged.
- R11: A pulse on `berr_clr` lowers `berr_irq` on the next cycle. If a write error arrives in the same cycle as the clear, the write error wins: `berr_irq` stays high and `berr_addr` takes the new address.
- R12: Responses without an error change neither the fault output nor the interrupt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle (low while a read error is reported) |
| req_addr | input | ADDR_W | Request physical address |
| req_kind | input | 2 | 0 load, 1 store, 2 atomic, 3 reserved |
| req_size | input | 2 | Size code: 1, 2, 4 or 8 bytes |
| req_tag | input | TAG_W | Request tag |
| fwd_valid | output | 1 | Request forwarded to the bus |
| fwd_addr | output | PA_W | Forwarded address |
| fwd_kind | output | 2 | Forwarded kind |
| fwd_size | output | 2 | Forwarded size |
| fwd_tag | output | TAG_W | Forwarded tag |
| rsp_valid | input | 1 | Bus response present |
| rsp_err | input | 1 | Response carries an error |
| rsp_wr | input | 1 | Response belongs to a write |
| rsp_tag | input | TAG_W | Tag of the responding request |
| rsp_addr | input | PA_W | Address of the responding request |
| flt_valid | output | 1 | Precise fault reported |
| flt_cause | output | 2 | 1 load access, 2 store/atomic access, 3 load bus error |
| flt_tag | output | TAG_W | Tag of the faulting request |
| berr_irq | output | 1 | Sticky bus-error interrupt pending |
| berr_addr | output | PA_W | Address of the first failing write |
| berr_clr | input | 1 | Clear pulse for the interrupt |

## Verification
Two pairs of events can meet in the same cycle. The first pair is a read-error response and a new request. The bench presents a request that would otherwise be forwarded while a read error is active. It then checks that the fault carries the response's tag with cause 3, that `req_ready` is low and that nothing is forwarded. The second pair is a write error and a clear pulse. The bench raises both together and then checks, one cycle later, that the interrupt is still pending and that the recorded address has moved to the new write.

// File: rtl/pma_pkg.sv
package pma_pkg;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_AMO   = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CLS_VACANT = 2'd0,
        CLS_MEM    = 2'd1,
        CLS_IO     = 2'd2
    } region_cls_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_LD_ACC   = 2'd1,
        CAUSE_ST_ACC   = 2'd2,
        CAUSE_LD_BUSER = 2'd3
    } flt_cause_e;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef struct packed {
        region_cls_e cls;
        logic        rd_only;
        logic        no_amo;
        logic        word_only;
    } region_attr_t;

endpackage

// File: rtl/pma_region_lookup.sv
module pma_region_lookup
    import pma_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int PA_W   = 32,
    parameter int NREG   = 4,
    parameter logic [NREG-1:0][PA_W-1:0] REG_BASE  = '0,
    parameter logic [NREG-1:0][PA_W-1:0] REG_SIZE  = '0,
    parameter logic [NREG-1:0][1:0]      REG_CLASS = '0,
    parameter logic [NREG-1:0]           REG_RO    = '0,
    parameter logic [NREG-1:0]           REG_NOAMO = '0,
    parameter logic [NREG-1:0]           REG_W32   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output region_attr_t      attr
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic [PA_W-1:0] pa;
    logic            above_pa;
    logic [NREG-1:0] hit;
    logic [IDX_W-1:0] sel;
    logic            any_hit;

    assign pa = addr[PA_W-1:0];

    generate
        if (ADDR_W > PA_W) begin : g_hi
            assign above_pa = |addr[ADDR_W-1:PA_W];
        end else begin : g_nohi
            assign above_pa = 1'b0;
        end
    endgenerate

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            logic [PA_W-1:0] off;
            assign off    = pa - REG_BASE[i];
            assign hit[i] = (pa >= REG_BASE[i]) && (off < REG_SIZE[i]);
        end
    endgenerate

    always_comb begin
        sel     = '0;
        any_hit = 1'b0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel     = IDX_W'(i);
                any_hit = 1'b1;
            end
        end
    end

    always_comb begin
        attr.cls       = CLS_VACANT;
        attr.rd_only   = 1'b0;
        attr.no_amo    = 1'b0;
        attr.word_only = 1'b0;
        if (any_hit && !above_pa) begin
            attr.cls       = region_cls_e'(REG_CLASS[sel]);
            attr.rd_only   = REG_RO[sel];
            attr.no_amo    = REG_NOAMO[sel];
            attr.word_only = REG_W32[sel];
        end
    end

endmodule

// File: rtl/pma_access_rules.sv
module pma_access_rules
    import pma_pkg::*;
(
    input  region_attr_t attr,
    input  logic [1:0]   kind,
    input  logic [1:0]   size,
    output logic         deny,
    output logic [1:0]   cause
);
    logic size_bad;

    always_comb begin
        size_bad = attr.word_only && (size != SIZE_WORD);
        deny     = 1'b0;
        if (attr.cls == CLS_VACANT) begin
            deny = 1'b1;
        end else begin
            unique case (acc_kind_e'(kind))
                KIND_LOAD:  deny = size_bad;
                KIND_STORE: deny = size_bad || attr.rd_only;
                KIND_AMO:   deny = size_bad || attr.rd_only || attr.no_amo;
                default:    deny = 1'b1;
            endcase
        end
        cause = (acc_kind_e'(kind) == KIND_LOAD) ? CAUSE_LD_ACC : CAUSE_ST_ACC;
    end

endmodule

// File: rtl/pma_berr_track.sv
module pma_berr_track #(
    parameter int PA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_err,
    input  logic [PA_W-1:0] err_addr,
    input  logic            clr,
    output logic            pend,
    output logic [PA_W-1:0] pend_addr
);
    typedef struct packed {
        logic            pend;
        logic [PA_W-1:0] addr;
    } berr_state_t;

    berr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.pend = 1'b0;
        end
        if (wr_err) begin
            if (!st_q.pend || clr) begin
                st_d.addr = err_addr;
            end
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend      = st_q.pend;
    assign pend_addr = st_q.addr;

endmodule

// File: rtl/pma_gate.sv
module pma_gate
    import pma_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int PA_W   = 32,
    parameter int TAG_W  = 6,
    parameter int NREG   = 4,
    parameter logic [NREG-1:0][PA_W-1:0] REG_BASE  =
        {32'h2000_0000, 32'h8000_0000, 32'h1000_0000, 32'h1000_0000},
    parameter logic [NREG-1:0][PA_W-1:0] REG_SIZE  =
        {32'h0000_1000, 32'h1000_0000, 32'h0001_0000, 32'h0000_1000},
    parameter logic [NREG-1:0][1:0]      REG_CLASS = {2'd0, 2'd1, 2'd2, 2'd2},
    parameter logic [NREG-1:0]           REG_RO    = 4'b0010,
    parameter logic [NREG-1:0]           REG_NOAMO = 4'b0001,
    parameter logic [NREG-1:0]           REG_W32   = 4'b0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_size,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              fwd_valid,
    output logic [PA_W-1:0]   fwd_addr,
    output logic [1:0]        fwd_kind,
    output logic [1:0]        fwd_size,
    output logic [TAG_W-1:0]  fwd_tag,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic              rsp_wr,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [PA_W-1:0]   rsp_addr,
    output logic              flt_valid,
    output logic [1:0]        flt_cause,
    output logic [TAG_W-1:0]  flt_tag,
    output logic              berr_irq,
    output logic [PA_W-1:0]   berr_addr,
    input  logic              berr_clr
);
    region_attr_t attr;
    logic         deny;
    logic [1:0]   acc_cause;
    logic         rd_err;
    logic         wr_err;
    logic         accept;

    pma_region_lookup #(
        .ADDR_W   (ADDR_W),
        .PA_W     (PA_W),
        .NREG     (NREG),
        .REG_BASE (REG_BASE),
        .REG_SIZE (REG_SIZE),
        .REG_CLASS(REG_CLASS),
        .REG_RO   (REG_RO),
        .REG_NOAMO(REG_NOAMO),
        .REG_W32  (REG_W32)
    ) u_lookup (
        .addr(req_addr),
        .attr(attr)
    );

    pma_access_rules u_rules (
        .attr (attr),
        .kind (req_kind),
        .size (req_size),
        .deny (deny),
        .cause(acc_cause)
    );

    pma_berr_track #(.PA_W(PA_W)) u_berr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_err   (wr_err),
        .err_addr (rsp_addr),
        .clr      (berr_clr),
        .pend     (berr_irq),
        .pend_addr(berr_addr)
    );

    always_comb begin
        rd_err    = rsp_valid && rsp_err && !rsp_wr;
        wr_err    = rsp_valid && rsp_err && rsp_wr;
        req_ready = !rd_err;
        accept    = req_valid && req_ready;

        fwd_valid = accept && !deny;
        fwd_addr  = req_addr[PA_W-1:0];
        fwd_kind  = req_kind;
        fwd_size  = req_size;
        fwd_tag   = req_tag;

        flt_valid = 1'b0;
        flt_cause = CAUSE_NONE;
        flt_tag   = '0;
        if (rd_err) begin
            flt_valid = 1'b1;
            flt_cause = CAUSE_LD_BUSER;
            flt_tag   = rsp_tag;
        end else if (accept && deny) begin
            flt_valid = 1'b1;
            flt_cause = acc_cause;
            flt_tag   = req_tag;
        end
    end

endmodule

// File: rtl/pma_gate_chk.sv
module pma_gate_chk #(
    parameter int ADDR_W = 40,
    parameter int PA_W   = 32,
    parameter int TAG_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_kind,
    input logic [TAG_W-1:0]  req_tag,
    input logic              fwd_valid,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              rsp_wr,
    input logic [TAG_W-1:0]  rsp_tag,
    input logic              flt_valid,
    input logic [1:0]        flt_cause,
    input logic [TAG_W-1:0]  flt_tag,
    input logic              berr_irq,
    input logic [PA_W-1:0]   berr_addr,
    input logic              berr_clr
);
    // R3: forward and fault never together
    a_r3_fwd_flt_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_valid && flt_valid));

    // R3: an accepted request is either forwarded or faulted, with its tag
    a_r3_accept_resolves: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (fwd_valid || (flt_valid && flt_tag == req_tag)));

    // R4: nothing above the implemented width is ever forwarded
    a_r4_hi_bits_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (req_addr[ADDR_W-1:PA_W] == '0));

    // R8: reserved kind never forwarded
    a_r8_rsvd_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |-> !fwd_valid);

    // R9: read error reported precisely and stalls the request port
    a_r9_rd_err_precise: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err && !rsp_wr) |->
            (flt_valid && flt_cause == 2'd3 && flt_tag == rsp_tag && !req_ready && !fwd_valid));

    // R10: write error sets the pending interrupt
    a_r10_wr_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err && rsp_wr) |=> berr_irq);

    // R10: captured address holds while pending and not cleared
    a_r10_addr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_irq && !berr_clr) |=> (berr_irq && $stable(berr_addr)));

    // R11: clear without a new write error drops the interrupt
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_clr && !(rsp_valid && rsp_err && rsp_wr)) |=> !berr_irq);

    // R12: interrupt rises only after a write error
    a_r12_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(berr_irq) |-> $past(rsp_valid && rsp_err && rsp_wr));

endmodule

bind pma_gate pma_gate_chk #(.ADDR_W(ADDR_W), .PA_W(PA_W), .TAG_W(TAG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .req_kind (req_kind),
    .req_tag  (req_tag),
    .fwd_valid(fwd_valid),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_wr   (rsp_wr),
    .rsp_tag  (rsp_tag),
    .flt_valid(flt_valid),
    .flt_cause(flt_cause),
    .flt_tag  (flt_tag),
    .berr_irq (berr_irq),
    .berr_addr(berr_addr),
    .berr_clr (berr_clr)
);

// File: tb/tb_pma_gate.sv
module tb_pma_gate;
    localparam int ADDR_W = 40;
    localparam int PA_W   = 32;
    localparam int TAG_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_kind = '0;
    logic [1:0]        req_size = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              fwd_valid;
    logic [PA_W-1:0]   fwd_addr;
    logic [1:0]        fwd_kind;
    logic [1:0]        fwd_size;
    logic [TAG_W-1:0]  fwd_tag;
    logic              rsp_valid = 1'b0;
    logic              rsp_err = 1'b0;
    logic              rsp_wr = 1'b0;
    logic [TAG_W-1:0]  rsp_tag = '0;
    logic [PA_W-1:0]   rsp_addr = '0;
    logic              flt_valid;
    logic [1:0]        flt_cause;
    logic [TAG_W-1:0]  flt_tag;
    logic              berr_irq;
    logic [PA_W-1:0]   berr_addr;
    logic              berr_clr = 1'b0;

    always #10 clk = ~clk;

    pma_gate dut (.*);

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        kind;
        logic [1:0]        size;
        logic              fwd;
        logic [1:0]        cause;
    } vec_t;

    localparam int NV = 16;
    // kind: 0 load, 1 store, 2 atomic, 3 reserved; cause 1 load, 2 store/atomic
    localparam vec_t TBL [NV] = '{
        '{40'h00_8000_0040, 2'd0, 2'd3, 1'b1, 2'd0},  // R1 memory load
        '{40'h00_8000_0040, 2'd2, 2'd2, 1'b1, 2'd0},  // R1 memory atomic
        '{40'h00_8000_0041, 2'd1, 2'd0, 1'b1, 2'd0},  // R1 memory store
        '{40'h00_1000_0010, 2'd0, 2'd2, 1'b1, 2'd0},  // R5 word load ok
        '{40'h00_1000_0010, 2'd0, 2'd1, 1'b0, 2'd1},  // R5 half load fault
        '{40'h00_1000_0010, 2'd1, 2'd3, 1'b0, 2'd2},  // R5 dword store fault
        '{40'h00_1000_0010, 2'd1, 2'd2, 1'b1, 2'd0},  // R1 region 0 beats read-only 1
        '{40'h00_1000_0010, 2'd2, 2'd2, 1'b0, 2'd2},  // R6 atomic blocked
        '{40'h00_1000_2000, 2'd0, 2'd0, 1'b1, 2'd0},  // R7 load ok in read-only
        '{40'h00_1000_2000, 2'd1, 2'd3, 1'b0, 2'd2},  // R7 store fault
        '{40'h00_1000_2000, 2'd2, 2'd2, 1'b0, 2'd2},  // R7 atomic fault
        '{40'h00_2000_0100, 2'd0, 2'd2, 1'b0, 2'd1},  // R2 explicit vacant
        '{40'h00_0000_0000, 2'd1, 2'd2, 1'b0, 2'd2},  // R2 unmapped vacant
        '{40'h01_8000_0040, 2'd0, 2'd3, 1'b0, 2'd1},  // R4 high bit set
        '{40'h00_8FFF_FFFF, 2'd0, 2'd0, 1'b1, 2'd0},  // R1 last memory byte
        '{40'h00_8000_0000, 2'd3, 2'd2, 1'b0, 2'd2}   // R8 reserved kind
    };

    initial begin
        // reset state
        #5;
        chk("R12 reset irq", 64'(berr_irq), 64'd0);
        chk("R3 reset fwd", 64'(fwd_valid), 64'd0);
        chk("R3 reset flt", 64'(flt_valid), 64'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            req_valid = 1'b1;
            req_addr  = TBL[i].addr;
            req_kind  = TBL[i].kind;
            req_size  = TBL[i].size;
            req_tag   = TAG_W'(i + 3);
            #2;
            chk($sformatf("R3 vec%0d fwd", i), 64'(fwd_valid), 64'(TBL[i].fwd));
            chk($sformatf("R3 vec%0d flt", i), 64'(flt_valid), 64'(!TBL[i].fwd));
            if (TBL[i].fwd) begin
                chk($sformatf("R3 vec%0d fields", i),
                    {fwd_addr, fwd_kind, fwd_size, fwd_tag},
                    64'({TBL[i].addr[PA_W-1:0], TBL[i].kind, TBL[i].size, TAG_W'(i + 3)}));
            end else begin
                chk($sformatf("R8 vec%0d cause", i), 64'(flt_cause), 64'(TBL[i].cause));
                chk($sformatf("R3 vec%0d tag", i), 64'(flt_tag), 64'(i + 3));
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        #2;
        chk("R3 idle no fwd", 64'(fwd_valid | flt_valid), 64'd0);

        // R9: read error collides with a forwardable request
        req_valid = 1'b1;
        req_addr  = 40'h00_8000_0000;
        req_kind  = 2'd0;
        req_size  = 2'd2;
        req_tag   = 6'd9;
        rsp_valid = 1'b1; rsp_err = 1'b1; rsp_wr = 1'b0; rsp_tag = 6'd21;
        #2;
        chk("R9 flt valid", 64'(flt_valid), 64'd1);
        chk("R9 cause", 64'(flt_cause), 64'd3);
        chk("R9 tag", 64'(flt_tag), 64'd21);
        chk("R9 ready low", 64'(req_ready), 64'd0);
        chk("R9 no fwd", 64'(fwd_valid), 64'd0);
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
        #2;
        chk("R9 request resumes", 64'(fwd_valid), 64'd1);
        chk("R10 read error no irq", 64'(berr_irq), 64'd0);
        req_valid = 1'b0;

        // R12: clean responses do nothing
        rsp_valid = 1'b1; rsp_err = 1'b0; rsp_wr = 1'b1; rsp_addr = 32'h8000_0100;
        #2;
        chk("R12 clean rsp flt", 64'(flt_valid), 64'd0);
        @(negedge clk);
        chk("R12 clean rsp irq", 64'(berr_irq), 64'd0);

        // R10: first write error captured
        rsp_err = 1'b1; rsp_wr = 1'b1; rsp_addr = 32'h8000_0A00;
        #2;
        chk("R10 write error no precise fault", 64'(flt_valid), 64'd0);
        @(negedge clk);
        chk("R10 irq set", 64'(berr_irq), 64'd1);
        chk("R10 addr", 64'(berr_addr), 64'h8000_0A00);
        rsp_addr = 32'h8000_0B00;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
        chk("R10 second error keeps first", 64'(berr_addr), 64'h8000_0A00);
        chk("R10 still pending", 64'(berr_irq), 64'd1);
        @(negedge clk);
        chk("R10 sticky", 64'(berr_irq), 64'd1);

        // R11: clear
        berr_clr = 1'b1;
        @(negedge clk);
        berr_clr = 1'b0;
        chk("R11 cleared", 64'(berr_irq), 64'd0);

        // R11: set with no pending, then clear and new error together
        rsp_valid = 1'b1; rsp_err = 1'b1; rsp_wr = 1'b1; rsp_addr = 32'h1000_2004;
        @(negedge clk);
        chk("R10 re-arm addr", 64'(berr_addr), 64'h1000_2004);
        rsp_addr = 32'h8000_0C00;
        berr_clr = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0; berr_clr = 1'b0;
        chk("R11 set wins irq", 64'(berr_irq), 64'd1);
        chk("R11 set wins addr", 64'(berr_addr), 64'h8000_0C00);

        finish_run();
    end

endmodule